// File: doc/BRIEF.md
# Fractional-Increment Realtime Counter

This block keeps a 64-bit time count that advances at a fixed nominal rate, whatever the frequency of the clock that drives it. On every clock edge a 12-bit step value is added to a phase accumulator. When the accumulator reaches a 12-bit modulus, the modulus is subtracted, the count advances by one and a one-cycle strobe is raised. The step/modulus ratio is chosen so that the product of clock rate and ratio gives the target rate. For example, 64/125 at 12 MHz, 8/25 at 19.2 MHz, 192/625 at 20 MHz and 4/25 at 38.4 MHz all give 6.144 MHz.

A slow reference tick, nominally 32.768 kHz, can re-align the count. Exactly 375 fine counts belong to every two reference ticks. The alignment state machine has three states. ALN_NOBASE means no baseline has been captured. ALN_HALF1 means a baseline is held and the first tick of a pair is awaited. ALN_HALF2 means the closing tick of the pair is awaited. Transition T1 (ALN_NOBASE to ALN_HALF1) runs on a tick and captures the count as the baseline. Transition T2 (ALN_HALF1 to ALN_HALF2) runs on a tick. Transition T3 (ALN_HALF2 to ALN_HALF1) runs on a tick, compares the count against baseline plus 375, loads that value if they differ, and advances the baseline. Transition T4 returns any state to ALN_NOBASE whenever correction is switched off. If the reference is derived from the system clock rather than from a crystal, software programs 75/244 so that the fine rate agrees with the coarse one.

Top module: `frac_rate_counter`

## Requirements
- R1: Synchronous active-high reset sets the count to zero, clears the strobe, the phase and the alignment state, and sets step = 4 and modulus = 25. After release, the count rises by 40 in 250 clocks.
- R2: On each clock, step is added to the phase. When the sum is at least the modulus, the modulus is subtracted, the count rises by one and inc_pulse is high for that one cycle, in the same cycle the count changes. Starting from zero phase with step below modulus, N clocks raise the count by floor(N*step/modulus), with the same number of strobes.
- R3: A write with wr_en high loads the step from wr_data[11:0] at wr_addr 0x10, or the modulus from wr_data[11:0] at wr_addr 0x14. Bits 31:12 of wr_data have no effect.
- R4: Writes to any other address change neither the ratio nor the phase.
- R5: A write to either ratio register clears the phase at the edge that takes it, and no increment happens at that edge.
- R6: A modulus of zero stops all fine increments: inc_pulse stays low and the count holds, except for loads made under R8.
- R7: ref_tick is asynchronous. It passes through a two-flop synchroniser and a rising-edge detector. A rise that is driven between clock edges takes effect at the third following clock edge.
- R8: With corr_en high, the first reference tick captures the baseline. Every second tick after that checks the count against baseline + 375, loads that value if they differ, and makes it the new baseline.
- R9: A count that matches the expected value at a pair-closing tick is left untouched, so a ratio that yields exactly 375 counts per tick pair runs exactly at step/modulus.
- R10: With corr_en low, ticks never alter the count, and alignment restarts from ALN_NOBASE when corr_en rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset (0x10 step, 0x14 modulus) |
| wr_data | input | 32 | Write data; only bits 11:0 are used |
| ref_tick | input | 1 | Asynchronous slow reference tick |
| corr_en | input | 1 | Enables re-alignment from the reference |
| count | output | 64 | Realtime count value |
| inc_pulse | output | 1 | One-cycle strobe for each fine increment |

## Verification
The phase-bound and single-step checks assume that the programmed step is always below a non-zero modulus, because the accumulator subtracts the modulus only once per clock. The stimulus respects this by first writing a zero modulus, then the new step, then the new modulus, so an oversized step is never active together with a non-zero modulus. The alignment checks also assume reference pulses that are wide and far apart compared with the clock, and every tick in the stimulus is high for three cycles and is separated from the next by many cycles.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic [1:0] {
        ALN_NOBASE = 2'd0,
        ALN_HALF1  = 2'd1,
        ALN_HALF2  = 2'd2
    } aln_state_e;

endpackage

// File: rtl/frc_ratio_regs.sv
module frc_ratio_regs #(
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 32,
    parameter int                RATIO_W = 12,
    parameter logic [ADDR_W-1:0] NUM_OFS = 8'h10,
    parameter logic [ADDR_W-1:0] DEN_OFS = 8'h14,
    parameter int                NUM_RST = 4,
    parameter int                DEN_RST = 25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [RATIO_W-1:0] num_q,
    output logic [RATIO_W-1:0] den_q,
    output logic               ratio_wr
);

    logic num_hit;
    logic den_hit;
    logic unused_hi;

    assign num_hit   = wr_en && (wr_addr == NUM_OFS);
    assign den_hit   = wr_en && (wr_addr == DEN_OFS);
    assign ratio_wr  = num_hit || den_hit;
    assign unused_hi = ^wr_data[DATA_W-1:RATIO_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            num_q <= RATIO_W'(NUM_RST);
            den_q <= RATIO_W'(DEN_RST);
        end else begin
            if (num_hit) begin
                num_q <= wr_data[RATIO_W-1:0];
            end
            if (den_hit) begin
                den_q <= wr_data[RATIO_W-1:0];
            end
        end
    end

endmodule

// File: rtl/frc_phase_acc.sv
module frc_phase_acc #(
    parameter int RATIO_W = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic [RATIO_W-1:0] num,
    input  logic [RATIO_W-1:0] den,
    output logic               step_d,
    output logic               step_q,
    output logic [RATIO_W-1:0] acc_q
);

    localparam int SUM_W = RATIO_W + 1;

    logic [SUM_W-1:0]   sum;
    logic [SUM_W-1:0]   den_ext;
    logic [SUM_W-1:0]   wrapped;
    logic               den_zero;
    logic [RATIO_W-1:0] acc_d;

    assign sum      = {1'b0, acc_q} + {1'b0, num};
    assign den_ext  = {1'b0, den};
    assign wrapped  = sum - den_ext;
    assign den_zero = (den == '0);
    assign step_d   = !clr && !den_zero && (sum >= den_ext);

    always_comb begin
        if (clr) begin
            acc_d = '0;
        end else if (den_zero) begin
            acc_d = acc_q;
        end else if (step_d) begin
            acc_d = wrapped[RATIO_W-1:0];
        end else begin
            acc_d = sum[RATIO_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            step_q <= 1'b0;
        end else begin
            acc_q  <= acc_d;
            step_q <= step_d;
        end
    end

endmodule

// File: rtl/frc_ref_sync.sv
module frc_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] && !last_q;

endmodule

// File: rtl/frc_align_fsm.sv
module frc_align_fsm
    import frc_pkg::*;
#(
    parameter int CNT_W       = 64,
    parameter int PAIR_COUNTS = 375
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             corr_en,
    input  logic             tick,
    input  logic [CNT_W-1:0] count,
    output logic             fix_now,
    output logic [CNT_W-1:0] fix_val,
    output aln_state_e       state_q
);

    aln_state_e       state_d;
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] base_d;
    logic [CNT_W-1:0] expect_val;

    assign expect_val = base_q + CNT_W'(PAIR_COUNTS);

    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        if (!corr_en) begin
            state_d = ALN_NOBASE;
        end else if (tick) begin
            unique case (state_q)
                ALN_NOBASE: begin
                    state_d = ALN_HALF1;
                    base_d  = count;
                end
                ALN_HALF1: begin
                    state_d = ALN_HALF2;
                end
                ALN_HALF2: begin
                    state_d = ALN_HALF1;
                    base_d  = expect_val;
                end
                default: begin
                    state_d = ALN_NOBASE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ALN_NOBASE;
            base_q  <= '0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
        end
    end

    always_comb begin
        fix_now = 1'b0;
        fix_val = expect_val;
        unique case (state_q)
            ALN_NOBASE: fix_now = 1'b0;
            ALN_HALF1:  fix_now = 1'b0;
            ALN_HALF2:  fix_now = corr_en && tick && (count != expect_val);
            default:    fix_now = 1'b0;
        endcase
    end

endmodule

// File: rtl/frac_rate_counter.sv
module frac_rate_counter
    import frc_pkg::*;
#(
    parameter int         CNT_W       = 64,
    parameter int         RATIO_W     = 12,
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 32,
    parameter int         NUM_RST     = 4,
    parameter int         DEN_RST     = 25,
    parameter int         PAIR_COUNTS = 375,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] NUM_OFS     = 8'h10,
    parameter logic [7:0] DEN_OFS     = 8'h14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ref_tick,
    input  logic              corr_en,
    output logic [CNT_W-1:0]  count,
    output logic              inc_pulse
);

    logic [RATIO_W-1:0] num_q;
    logic [RATIO_W-1:0] den_q;
    logic [RATIO_W-1:0] acc_q;
    logic               ratio_wr;
    logic               step_d;
    logic               tick;
    logic               fix_now;
    logic [CNT_W-1:0]   fix_val;
    logic [CNT_W-1:0]   count_q;
    aln_state_e         aln_state;

    frc_ratio_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .RATIO_W(RATIO_W),
        .NUM_OFS(ADDR_W'(NUM_OFS)),
        .DEN_OFS(ADDR_W'(DEN_OFS)),
        .NUM_RST(NUM_RST),
        .DEN_RST(DEN_RST)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .num_q   (num_q),
        .den_q   (den_q),
        .ratio_wr(ratio_wr)
    );

    frc_phase_acc #(
        .RATIO_W(RATIO_W)
    ) u_phase (
        .clk   (clk),
        .rst   (rst),
        .clr   (ratio_wr),
        .num   (num_q),
        .den   (den_q),
        .step_d(step_d),
        .step_q(inc_pulse),
        .acc_q (acc_q)
    );

    frc_ref_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(ref_tick),
        .rise    (tick)
    );

    frc_align_fsm #(
        .CNT_W      (CNT_W),
        .PAIR_COUNTS(PAIR_COUNTS)
    ) u_align (
        .clk    (clk),
        .rst    (rst),
        .corr_en(corr_en),
        .tick   (tick),
        .count  (count_q),
        .fix_now(fix_now),
        .fix_val(fix_val),
        .state_q(aln_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (fix_now) begin
            count_q <= fix_val;
        end else if (step_d) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count = count_q;

endmodule

// File: rtl/frac_rate_counter_chk.sv
module frac_rate_counter_chk
    import frc_pkg::*;
#(
    parameter int CNT_W   = 64,
    parameter int RATIO_W = 12,
    parameter int NUM_RST = 4,
    parameter int DEN_RST = 25
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_hit,
    input logic [RATIO_W-1:0] acc,
    input logic [RATIO_W-1:0] num,
    input logic [RATIO_W-1:0] den,
    input logic               inc_pulse,
    input logic [CNT_W-1:0]   count,
    input logic               fix_now,
    input logic [CNT_W-1:0]   fix_val,
    input logic               corr_en,
    input aln_state_e         state
);

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (count == '0) && !inc_pulse && (acc == '0)
                       && (num == RATIO_W'(NUM_RST)) && (den == RATIO_W'(DEN_RST)));

    assert_count_steps_R2: assert property (@(posedge clk) disable iff (rst)
        !fix_now |=> count == $past(count) + CNT_W'(inc_pulse));

    assert_phase_bound_R2: assert property (@(posedge clk) disable iff (rst)
        (den != '0) |-> acc < den);

    assert_wr_clears_R5: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (acc == '0) && !inc_pulse);

    assert_den_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (den == '0) |=> !inc_pulse);

    assert_fix_load_R8: assert property (@(posedge clk) disable iff (rst)
        fix_now |=> count == $past(fix_val));

    assert_corr_off_R10: assert property (@(posedge clk) disable iff (rst)
        !corr_en |=> (state == ALN_NOBASE));

endmodule

bind frac_rate_counter frac_rate_counter_chk #(
    .CNT_W  (CNT_W),
    .RATIO_W(RATIO_W),
    .NUM_RST(NUM_RST),
    .DEN_RST(DEN_RST)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_hit   (ratio_wr),
    .acc      (acc_q),
    .num      (num_q),
    .den      (den_q),
    .inc_pulse(inc_pulse),
    .count    (count),
    .fix_now  (fix_now),
    .fix_val  (fix_val),
    .corr_en  (corr_en),
    .state    (aln_state)
);

// File: tb/frac_rate_counter_bench.sv
module frac_rate_counter_bench;

    localparam logic [7:0] OFS_NUM = 8'h10;
    localparam logic [7:0] OFS_DEN = 8'h14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        ref_tick = 1'b0;
    logic        corr_en = 1'b0;
    logic [63:0] count;
    logic        inc_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int pulses   = 0;

    always #5 clk = ~clk;

    frac_rate_counter u_frac_rate_counter (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ref_tick (ref_tick),
        .corr_en  (corr_en),
        .count    (count),
        .inc_pulse(inc_pulse)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_ratio(input int n, input int d);
        wr(OFS_DEN, 32'h0);
        wr(OFS_NUM, 32'(n));
        wr(OFS_DEN, 32'(d));
    endtask

    task automatic run(input int n);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (inc_pulse) pulses++;
        end
    endtask

    task automatic tick_pulse();
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (3) @(negedge clk);
        ref_tick = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [63:0] c0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "count in reset", count, 64'd0);
        check("R1", "strobe in reset", {63'd0, inc_pulse}, 64'd0);
        rst = 1'b0;
        c0 = count;
        run(250);
        check("R1", "default 4/25 over 250", count - c0, 64'd40);
        check("R2", "strobes at default", 64'(pulses), 64'd40);
    endtask

    task automatic t_ratio(input int n, input int d, input int cyc);
        logic [63:0] c0;
        logic [63:0] exp;
        set_ratio(n, d);
        c0  = count;
        exp = 64'((longint'(cyc) * n) / d);
        run(cyc);
        check("R2", $sformatf("count for %0d/%0d", n, d), count - c0, exp);
        check("R2", $sformatf("strobes for %0d/%0d", n, d), 64'(pulses), exp);
    endtask

    task automatic t_upper_bits();
        logic [63:0] c0;
        wr(OFS_DEN, 32'hABCDE000);
        wr(OFS_NUM, 32'h12345040);
        wr(OFS_DEN, 32'hFFFFF07D);
        c0 = count;
        run(250);
        check("R3", "upper bits ignored, 64/125", count - c0, 64'd128);
    endtask

    task automatic t_bad_addr();
        logic [63:0] c0;
        set_ratio(4, 25);
        c0 = count;
        wr(8'h18, 32'h1);
        wr(8'h11, 32'h1);
        run(246);
        check("R4", "other offsets ignored", count - c0, 64'd40);
    endtask

    task automatic t_write_clear();
        logic [63:0] c0;
        set_ratio(4, 25);
        run(5);
        c0 = count;
        wr(OFS_NUM, 32'd4);
        check("R5", "no step on write edges", count - c0, 64'd0);
        c0 = count;
        run(6);
        check("R5", "phase restarts at zero", count - c0, 64'd0);
        run(1);
        check("R5", "first step after 7 clocks", count - c0, 64'd1);
    endtask

    task automatic t_den_zero();
        logic [63:0] c0;
        wr(OFS_DEN, 32'h0);
        c0 = count;
        run(100);
        check("R6", "count holds", count - c0, 64'd0);
        check("R6", "no strobes", 64'(pulses), 64'd0);
    endtask

    task automatic t_correction();
        logic [63:0] c0;
        corr_en = 1'b0;
        wr(OFS_DEN, 32'h0);
        @(negedge clk);
        corr_en = 1'b1;
        c0 = count;
        tick_pulse();
        tick_pulse();
        check("R8", "no load before pair closes", count, c0);
        @(negedge clk);
        ref_tick = 1'b1;
        repeat (2) @(negedge clk);
        check("R7", "unchanged two edges after rise", count, c0);
        @(negedge clk);
        check("R7", "loaded at third edge", count, c0 + 64'd375);
        ref_tick = 1'b0;
        repeat (10) @(negedge clk);
        tick_pulse();
        tick_pulse();
        check("R8", "second pair loads again", count, c0 + 64'd750);
    endtask

    task automatic t_corr_off();
        logic [63:0] c0;
        corr_en = 1'b0;
        c0 = count;
        for (int k = 0; k < 4; k++) tick_pulse();
        check("R10", "ticks ignored when off", count, c0);
    endtask

    task automatic t_no_spurious();
        logic [63:0] c0;
        corr_en = 1'b0;
        set_ratio(1, 2);
        corr_en = 1'b1;
        c0 = count;
        for (int i = 0; i < 1875; i++) begin
            ref_tick = ((i % 375) < 3);
            @(negedge clk);
        end
        ref_tick = 1'b0;
        check("R9", "matching pairs leave count", count - c0, 64'd937);
        corr_en = 1'b0;
        check("R10", "fresh baseline after re-enable", count - c0, 64'd937);
    endtask

    initial begin
        t_reset();
        t_ratio(64, 125, 250);
        t_ratio(768, 1625, 1625);
        t_ratio(75, 244, 488);
        t_ratio(8, 25, 100);
        t_upper_bits();
        t_bad_addr();
        t_write_clear();
        t_den_zero();
        t_correction();
        t_corr_off();
        t_no_spurious();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule